// File: doc/BRIEF.md
# Hybrid-Partitioned SRAM Ternary Match Table

This block is a ternary match table that uses no per-cell comparators. The table holds `LAYERS*DEPTH` entries, and each entry is `NSUB*SUBW` bits wide. The storage is cut two ways:

- The key is split into `NSUB` slices of `SUBW` bits each.
- The entries are split into `LAYERS` groups of `DEPTH` consecutive indices.

Every (group, slice) pair owns a small RAM with `2^SUBW` rows of `DEPTH` bits. Bit `k` of row `r` is set exactly when local entry `k` accepts the slice value `r`.

A search works as follows:

1. Each key slice addresses a row in its RAM.
2. Within a group, the `NSUB` rows are ANDed to form a hit vector.
3. A per-group priority encoder picks the lowest local hit.
4. A second encoder picks the lowest group that has a hit.

One search can be accepted every cycle. The result is registered one cycle after acceptance.

Entries are written through a separate port. The port carries an index, a value and a care mask, where a care bit of 0 means "don't care". A writer state machine has two states:

- `WR_IDLE`: the writer waits for a request. The transition *start* fires on `wr_req`, which moves the writer to `WR_WALK` and latches the request.
- `WR_WALK`: on each cycle the writer visits one row number in all `NSUB` RAMs of the target group. It sets or clears that entry's bit according to whether the row value satisfies the ternary slice. The transition *step* keeps the writer in `WR_WALK` while rows remain. The transition *done* returns it to `WR_IDLE` after the last row.

While the writer is away from `WR_IDLE`, `busy` is high. During that time searches and further write requests are dropped. There is no separate delete operation: an entry is replaced by writing it again.

Top module: `hp_tcam`

## Requirements
- R1: After reset, `busy` and `res_valid` are low, and every key searched misses.
- R2: A search with `search_req` high while `busy` is low produces `res_valid` high on the next cycle, with the result for that key. Searches may be issued on consecutive cycles.
- R3: Entry `i` matches a key when, for every bit position where the care mask is 1, the key bit equals the stored value bit. Key bits under a care bit of 0 are ignored.
- R4: An entry written with an all-zero care mask matches every key.
- R5: When several entries match, the lowest index wins. The index is reported as `match_addr = group*DEPTH + local`, so the lowest group comes first and the lowest local index within that group.
- R6: On a miss, `match_found` is 0 and `match_addr` is 0.
- R7: `wr_req` accepted in `WR_IDLE` makes `busy` high from the next cycle for exactly `2^SUBW` cycles.
- R8: A search requested while `busy` is high is dropped: `res_valid` is low on the following cycle.
- R9: A `wr_req` raised while `busy` is high is dropped and leaves the table unchanged.
- R10: Rewriting an entry fully replaces its old value and mask. Other entries are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_req | input | 1 | Search request |
| search_key | input | NSUB*SUBW | Key to look up |
| res_valid | output | 1 | Result registers hold an accepted search |
| match_found | output | 1 | Some entry matched |
| match_addr | output | clog2(LAYERS*DEPTH) | Index of the winning entry, 0 on miss |
| wr_req | input | 1 | Entry write request |
| wr_index | input | clog2(LAYERS*DEPTH) | Entry to write |
| wr_value | input | NSUB*SUBW | Stored value |
| wr_care | input | NSUB*SUBW | Care mask, 1 = bit compared |
| busy | output | 1 | Writer active; searches and writes dropped |

## Verification
The assertions assume that the environment drives `search_req` and `wr_req` to known values at every clock edge once reset is released. They also assume the caller watches `busy` rather than counting on a write completing at a fixed time. The stimulus meets both assumptions:

- It drives every input from time zero, on the falling edge.
- It waits for `busy` to drop before issuing searches.
- It raises requests during `busy` only on purpose, to show that they are dropped.

Expected results come from a flat model of value and mask per entry, scanned from the lowest index. Every key of the small configuration is swept after each write.

// File: rtl/hp_tcam_pkg.sv
package hp_tcam_pkg;
    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_WALK = 1'b1
    } wr_state_e;
endpackage

// File: rtl/hp_tcam_layer.sv
module hp_tcam_layer #(
    parameter int SUBW  = 2,
    parameter int NSUB  = 3,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSUB*SUBW-1:0]     key,
    input  logic                     we,
    input  logic [SUBW-1:0]          wr_row,
    input  logic [$clog2(DEPTH)-1:0] wr_bit,
    input  logic [NSUB-1:0]          wr_set,
    output logic                     hit,
    output logic [$clog2(DEPTH)-1:0] hit_idx
);
    localparam int ROWS  = 1 << SUBW;
    localparam int LOC_W = $clog2(DEPTH);

    logic [NSUB-1:0][DEPTH-1:0] rd_row;
    logic [DEPTH-1:0]           and_vec;

    for (genvar u = 0; u < NSUB; u++) begin : g_unit
        logic [DEPTH-1:0] rows_q [ROWS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    rows_q[r] <= '0;
                end
            end else if (we) begin
                rows_q[wr_row][wr_bit] <= wr_set[u];
            end
        end

        assign rd_row[u] = rows_q[key[u*SUBW +: SUBW]];
    end

    always_comb begin
        and_vec = '1;
        for (int u = 0; u < NSUB; u++) begin
            and_vec = and_vec & rd_row[u];
        end
    end

    // Lowest local index wins (R5)
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (and_vec[i]) begin
                hit     = 1'b1;
                hit_idx = LOC_W'(i);
            end
        end
    end

    assert_hit_has_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> and_vec[hit_idx]);
    assert_miss_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (and_vec == '0));
endmodule

// File: rtl/hp_tcam_writer.sv
module hp_tcam_writer
    import hp_tcam_pkg::*;
#(
    parameter int SUBW   = 2,
    parameter int NSUB   = 3,
    parameter int LAYERS = 2,
    parameter int DEPTH  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_req,
    input  logic [$clog2(LAYERS*DEPTH)-1:0]   wr_index,
    input  logic [NSUB*SUBW-1:0]              wr_value,
    input  logic [NSUB*SUBW-1:0]              wr_care,
    output logic                              busy,
    output logic [LAYERS-1:0]                 layer_we,
    output logic [SUBW-1:0]                   row,
    output logic [$clog2(DEPTH)-1:0]          bit_idx,
    output logic [NSUB-1:0]                   set_vec
);
    localparam int KEY_W = NSUB * SUBW;
    localparam int LAY_W = $clog2(LAYERS);
    localparam int LOC_W = $clog2(DEPTH);
    localparam logic [SUBW-1:0] LAST_ROW = SUBW'((1 << SUBW) - 1);

    wr_state_e        state_q, state_d;
    logic [SUBW-1:0]  row_q;
    logic [LAY_W-1:0] lay_q;
    logic [LOC_W-1:0] loc_q;
    logic [KEY_W-1:0] val_q, care_q;

    // State register and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            row_q   <= '0;
            lay_q   <= '0;
            loc_q   <= '0;
            val_q   <= '0;
            care_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WR_IDLE && wr_req) begin
                lay_q  <= LAY_W'(int'(wr_index) / DEPTH);
                loc_q  <= LOC_W'(int'(wr_index) % DEPTH);
                val_q  <= wr_value;
                care_q <= wr_care;
                row_q  <= '0;
            end else if (state_q == WR_WALK) begin
                row_q <= row_q + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        busy     = 1'b0;
        layer_we = '0;
        row      = row_q;
        bit_idx  = loc_q;
        for (int u = 0; u < NSUB; u++) begin
            set_vec[u] = ((row_q ^ val_q[u*SUBW +: SUBW]) & care_q[u*SUBW +: SUBW]) == '0;
        end
        unique case (state_q)
            WR_IDLE: begin
                if (wr_req) state_d = WR_WALK;      // start
            end
            WR_WALK: begin
                busy = 1'b1;
                for (int l = 0; l < LAYERS; l++) begin
                    layer_we[l] = (lay_q == LAY_W'(l));
                end
                if (row_q == LAST_ROW) state_d = WR_IDLE;   // done, else step
            end
            default: state_d = WR_IDLE;
        endcase
    end

    assert_busy_from_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_req));
    assert_row_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (row_q == $past(row_q) + 1'b1));
    assert_request_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(val_q) && $stable(care_q) && $stable(lay_q) && $stable(loc_q)));
    assert_one_layer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(layer_we));
endmodule

// File: rtl/hp_tcam.sv
module hp_tcam #(
    parameter int SUBW   = 2,
    parameter int NSUB   = 3,
    parameter int LAYERS = 2,
    parameter int DEPTH  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              search_req,
    input  logic [NSUB*SUBW-1:0]              search_key,
    output logic                              res_valid,
    output logic                              match_found,
    output logic [$clog2(LAYERS*DEPTH)-1:0]   match_addr,
    input  logic                              wr_req,
    input  logic [$clog2(LAYERS*DEPTH)-1:0]   wr_index,
    input  logic [NSUB*SUBW-1:0]              wr_value,
    input  logic [NSUB*SUBW-1:0]              wr_care,
    output logic                              busy
);
    localparam int ENTRY_W = $clog2(LAYERS * DEPTH);
    localparam int LOC_W   = $clog2(DEPTH);

    logic [LAYERS-1:0]            layer_we;
    logic [SUBW-1:0]              wr_row;
    logic [LOC_W-1:0]             wr_bit;
    logic [NSUB-1:0]              wr_set;
    logic [LAYERS-1:0]            lay_hit;
    logic [LAYERS-1:0][LOC_W-1:0] lay_idx;
    logic                         any_hit;
    logic [ENTRY_W-1:0]           sel_addr;

    hp_tcam_writer #(.SUBW(SUBW), .NSUB(NSUB), .LAYERS(LAYERS), .DEPTH(DEPTH)) u_writer (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_index(wr_index),
        .wr_value(wr_value), .wr_care(wr_care), .busy(busy),
        .layer_we(layer_we), .row(wr_row), .bit_idx(wr_bit), .set_vec(wr_set)
    );

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        hp_tcam_layer #(.SUBW(SUBW), .NSUB(NSUB), .DEPTH(DEPTH)) u_layer (
            .clk(clk), .rst_n(rst_n), .key(search_key), .we(layer_we[l]),
            .wr_row(wr_row), .wr_bit(wr_bit), .wr_set(wr_set),
            .hit(lay_hit[l]), .hit_idx(lay_idx[l])
        );
    end

    // Cross-layer encoder: lowest layer wins (R5)
    always_comb begin
        any_hit  = 1'b0;
        sel_addr = '0;
        for (int l = LAYERS - 1; l >= 0; l--) begin
            if (lay_hit[l]) begin
                any_hit  = 1'b1;
                sel_addr = ENTRY_W'(l * DEPTH) + ENTRY_W'(lay_idx[l]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            match_found <= 1'b0;
            match_addr  <= '0;
        end else begin
            res_valid   <= search_req && !busy;
            match_found <= search_req && !busy && any_hit;
            match_addr  <= (search_req && !busy) ? sel_addr : '0;
        end
    end

    assert_result_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(search_req && !busy));
    assert_miss_addr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !match_found |-> (match_addr == '0));
    assert_found_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_found |-> res_valid);
endmodule

// File: tb/hp_tcam_test.sv
module hp_tcam_test;
    localparam int SUBW = 2, NSUB = 3, LAYERS = 2, DEPTH = 4;
    localparam int KEY_W = NSUB * SUBW;
    localparam int ENTRIES = LAYERS * DEPTH;
    localparam int ENTRY_W = $clog2(ENTRIES);
    localparam int KEYS = 1 << KEY_W;
    localparam int ROWS = 1 << SUBW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic search_req = 1'b0, wr_req = 1'b0;
    logic [KEY_W-1:0] search_key = '0, wr_value = '0, wr_care = '0;
    logic [ENTRY_W-1:0] wr_index = '0, match_addr;
    logic res_valid, match_found, busy;

    int checks = 0, errors = 0;
    logic [KEY_W-1:0] m_val [ENTRIES];
    logic [KEY_W-1:0] m_care [ENTRIES];
    bit m_used [ENTRIES];

    always #5 clk = ~clk;

    hp_tcam #(.SUBW(SUBW), .NSUB(NSUB), .LAYERS(LAYERS), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .search_req(search_req), .search_key(search_key),
        .res_valid(res_valid), .match_found(match_found), .match_addr(match_addr),
        .wr_req(wr_req), .wr_index(wr_index), .wr_value(wr_value), .wr_care(wr_care),
        .busy(busy)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_result(int key, string req);
        bit ef = 1'b0;
        int ea = 0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (m_used[i] && (((KEY_W'(key) ^ m_val[i]) & m_care[i]) == '0)) begin
                ef = 1'b1;
                ea = i;
            end
        end
        check(res_valid === 1'b1, req, "res_valid", int'(res_valid), 1);
        check(match_found === ef, req, "match_found", int'(match_found), int'(ef));
        check(match_addr === ENTRY_W'(ea), req, "match_addr (R5/R6)", int'(match_addr), ea);
    endtask

    // Back-to-back sweep of every key (R2)
    task automatic sweep(string req);
        for (int k = 0; k <= KEYS; k++) begin
            @(negedge clk);
            if (k > 0) check_result(k - 1, req);
            if (k < KEYS) begin
                search_req = 1'b1;
                search_key = KEY_W'(k);
            end else begin
                search_req = 1'b0;
            end
        end
    endtask

    task automatic do_write(int idx, logic [KEY_W-1:0] v, logic [KEY_W-1:0] c,
                            bit poke_s, bit poke_w, int idx2);
        int n = 0;
        @(negedge clk);
        search_req = 1'b0;
        wr_req = 1'b1;
        wr_index = ENTRY_W'(idx);
        wr_value = v;
        wr_care = c;
        @(negedge clk);
        wr_req = 1'b0;
        if (poke_s) begin
            search_req = 1'b1;
            search_key = v;
        end
        if (poke_w) begin
            wr_req = 1'b1;
            wr_index = ENTRY_W'(idx2);
            wr_value = ~v;
            wr_care = '1;
        end
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
            if (n == 1) begin
                if (poke_s) check(res_valid === 1'b0, "R8", "res_valid during busy", int'(res_valid), 0);
                search_req = 1'b0;
                wr_req = 1'b0;
            end
        end
        check(n == ROWS, "R7", "busy cycles", n, ROWS);
        m_val[idx] = v;
        m_care[idx] = c;
        m_used[idx] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s = 7;
        for (int i = 0; i < ENTRIES; i++) begin
            m_used[i] = 1'b0;
            m_val[i] = '0;
            m_care[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(res_valid === 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
        sweep("R1");
        // R3: exact and partial ternary entries
        do_write(5, 6'b101101, 6'b111111, 1'b0, 1'b0, 0);
        sweep("R3");
        do_write(2, 6'b001100, 6'b001111, 1'b0, 1'b0, 0);
        sweep("R3");
        // R5: overlapping entries across layers
        do_write(6, 6'b000000, 6'b000011, 1'b0, 1'b0, 0);
        sweep("R5");
        // R4: care mask zero matches everything
        do_write(7, 6'b110011, 6'b000000, 1'b0, 1'b0, 0);
        sweep("R4");
        do_write(4, 6'b000000, 6'b000000, 1'b0, 1'b0, 0);
        sweep("R5");
        // R10: rewrite replaces old content
        do_write(4, 6'b111000, 6'b111111, 1'b0, 1'b0, 0);
        sweep("R10");
        // R8 and R9: requests during busy are dropped
        do_write(1, 6'b010101, 6'b110011, 1'b1, 1'b0, 0);
        sweep("R8");
        do_write(3, 6'b100001, 6'b100001, 1'b0, 1'b1, 0);
        sweep("R9");
        // Mixed writes with arithmetic patterns
        for (int t = 0; t < 24; t++) begin
            s = s * 1103515245 + 12345;
            do_write((s >>> 16) & 7, KEY_W'(s >>> 20), KEY_W'((s >>> 8) | (s >>> 24)), 1'b0, 1'b0, 0);
            sweep("R10");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule